// File: doc/BRIEF.md
# Serial ADC Command and Readout Port

This block is the digital front end of an eleven-input, 12-bit sampling converter. A host talks to it over four wires: an active-low chip select, a serial command input, a serial I/O clock, and a serial result output with a separate pad-enable for its three-state driver. Within one 12-clock frame the host shifts in an 8-bit command, most significant bit first. The first four bits pick an analog channel or a test code, and the next four bits are configuration. At the same time the block shifts out the 12-bit result of the previous conversion. The I/O clock runs slower than the system clock, and all serial pins are brought into the system clock domain before use.

From the fourth falling I/O clock edge to the twelfth, the block holds a sample-enable output high so the analog front end can charge its capacitor array. On the twelfth falling edge it hands control to the conversion sequencer and pulls the end-of-conversion flag low. A built-in stand-in converter returns a code derived from the channel after a fixed number of system clocks. That code is loaded into the result register, and the flag goes high again.

Top module: `adc_serial_port`

## Requirements
- R1: After reset the pad enable `sdo_oe` is 0, `eoc` is 1, `sample_en` is 0, `chan_sel` is 0, and the held result is 0, so the first frame reads out all zeros.
- R2: While `cs_n` is high, `sdo_oe` is 0. After `cs_n` falls, `sdo_oe` is 1 and `sdo` already shows bit 11 of the held result before any I/O clock edge.
- R3: On each of the first eleven falling I/O clock edges of a frame, `sdo` moves to the next lower result bit, so the twelve bits sampled before each falling edge give the result MSB first.
- R4: Command bits are taken on rising I/O clock edges, MSB first. Bits 7..4 of the command appear on `chan_sel` after the fourth rising edge and not before. Bits 3..0 appear on `cfg_sel` after the eighth rising edge.
- R5: Data on `sdi` at rising edges 9 through 12 has no effect on `chan_sel` or `cfg_sel`.
- R6: `sample_en` rises at the fourth falling I/O clock edge and stays high until the twelfth falling edge, where it drops.
- R7: At the twelfth falling edge `eoc` goes low. With the default two-stage pin synchronizer it goes high again exactly `CONV_CYCLES`+5 system clocks after that pin edge, with the new result loaded.
- R8: The result for address 0..10 is address×372+3. Address 11 gives 2048 (mid-scale), address 12 gives 0, and addresses 13..15 give 4095 (full-scale).
- R9: If `cs_n` rises before the twelfth falling edge, the frame is dropped: `sample_en` returns to 0, no conversion starts, `eoc` stays 1, and the held result is read out unchanged in the next frame. Each fall of `cs_n` restarts the bit counters.
- R10: If a result load lands while a frame is open, the load wins. `sdo` shows bit 11 of the new result, and the rest of that frame's readout is the new result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial I/O clock from the host |
| sdi | input | 1 | Serial command input, MSB first |
| sdo | output | 1 | Serial result output, MSB first |
| sdo_oe | output | 1 | Enable for the three-state pad driver of `sdo` |
| eoc | output | 1 | End of conversion; low while a conversion runs |
| sample_en | output | 1 | High during the sampling window |
| chan_sel | output | 4 | Selected channel or test code |
| cfg_sel | output | 4 | Configuration nibble of the last command |

## Verification
The two functions that can collide are the result load from the conversion sequencer and the start or readout of a new frame. Both write the output shift register, and they fall in the same cycle when the host lowers chip select before the end-of-conversion flag has risen. The bench provokes this by opening the next frame right after a frame ends, without waiting for the flag. It judges the outcome by requiring that `sdo` show the new result's MSB once the flag rises, and that the scoreboard accept the full 12-bit readout of that frame as the newly converted code.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;
    localparam int RES_W       = 12;
    localparam int ADDR_W      = 4;
    localparam int CMD_W       = 8;
    localparam int CFG_W       = CMD_W - ADDR_W;
    localparam int FRAME_LEN   = 12;
    localparam int SAMPLE_FALL = 4;
    localparam int CNT_W       = $clog2(FRAME_LEN + 1);

    typedef logic [RES_W-1:0]  result_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CFG_W-1:0]  cfg_t;

    // serial pin events after synchronization
    typedef struct packed {
        logic sel;    // chip select active
        logic rise;   // I/O clock rising edge seen
        logic fall;   // I/O clock falling edge seen
        logic din;    // data input aligned with the edges
    } pin_evt_t;
endpackage

// File: rtl/sp_pin_sync.sv
module sp_pin_sync import adc_sp_pkg::*; #(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_n,
    input  logic     sclk,
    input  logic     sdi,
    output pin_evt_t evt
);
    typedef struct packed {
        logic [STAGES-1:0] cs;
        logic [STAGES-1:0] ck;
        logic [STAGES-1:0] di;
        logic              ck_last;
    } sync_t;

    sync_t sync_q, sync_d;

    always_comb begin
        sync_d         = sync_q;
        sync_d.cs      = {sync_q.cs[STAGES-2:0], cs_n};
        sync_d.ck      = {sync_q.ck[STAGES-2:0], sclk};
        sync_d.di      = {sync_q.di[STAGES-2:0], sdi};
        sync_d.ck_last = sync_q.ck[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.cs      <= '1;
            sync_q.ck      <= '0;
            sync_q.di      <= '0;
            sync_q.ck_last <= 1'b0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign evt.sel  = !sync_q.cs[STAGES-1];
    assign evt.rise =  sync_q.ck[STAGES-1] && !sync_q.ck_last;
    assign evt.fall = !sync_q.ck[STAGES-1] &&  sync_q.ck_last;
    assign evt.din  =  sync_q.di[STAGES-1];
endmodule

// File: rtl/sp_frame_seq.sv
module sp_frame_seq import adc_sp_pkg::*; (
    input  logic     clk,
    input  logic     rst_n,
    input  pin_evt_t evt,
    input  logic     load,
    input  result_t  load_val,
    output addr_t    chan,
    output cfg_t     cfg,
    output logic     sample_en,
    output logic     start,
    output logic     sdo,
    output logic     sdo_oe
);
    localparam logic [CNT_W-1:0] CMD_CNT  = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0] ADDR_LST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] CMD_LST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] FRM_CNT  = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] FRM_LST  = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] SMP_LST  = CNT_W'(SAMPLE_FALL - 1);
    localparam logic [CNT_W-1:0] SMP_CNT  = CNT_W'(SAMPLE_FALL);

    typedef struct packed {
        logic             open;
        logic [CNT_W-1:0] rises;
        logic [CNT_W-1:0] falls;
        logic [CMD_W-1:0] cmd;
        addr_t            chan;
        cfg_t             cfg;
        result_t          held;
        result_t          sr;
        logic             samp;
        logic             start;
    } frm_t;

    frm_t frm_q, frm_d;

    always_comb begin
        frm_d       = frm_q;
        frm_d.start = 1'b0;
        if (evt.sel && !frm_q.open) begin
            frm_d.open  = 1'b1;
            frm_d.rises = '0;
            frm_d.falls = '0;
            frm_d.samp  = 1'b0;
            frm_d.sr    = frm_q.held;
        end else if (!evt.sel && frm_q.open) begin
            frm_d.open = 1'b0;
            frm_d.samp = 1'b0;
        end else if (frm_q.open) begin
            if (evt.rise && frm_q.rises < CMD_CNT) begin
                frm_d.cmd   = {frm_q.cmd[CMD_W-2:0], evt.din};
                frm_d.rises = frm_q.rises + 1'b1;
                if (frm_q.rises == ADDR_LST) frm_d.chan = frm_d.cmd[ADDR_W-1:0];
                if (frm_q.rises == CMD_LST)  frm_d.cfg  = frm_d.cmd[CFG_W-1:0];
            end
            if (evt.fall && frm_q.falls < FRM_CNT) begin
                frm_d.falls = frm_q.falls + 1'b1;
                if (frm_q.falls < FRM_LST) frm_d.sr = {frm_q.sr[RES_W-2:0], 1'b0};
                if (frm_q.falls == SMP_LST) frm_d.samp = 1'b1;
                if (frm_q.falls == FRM_LST) begin
                    frm_d.samp  = 1'b0;
                    frm_d.start = 1'b1;
                end
            end
        end
        if (load) begin
            frm_d.held = load_val;
            frm_d.sr   = load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frm_q <= '0;
        else        frm_q <= frm_d;
    end

    assign chan      = frm_q.chan;
    assign cfg       = frm_q.cfg;
    assign sample_en = frm_q.samp;
    assign start     = frm_q.start;
    assign sdo       = frm_q.sr[RES_W-1];
    assign sdo_oe    = frm_q.open;

    // R6: the window opens exactly at the fourth falling edge
    a_r6_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm_q.samp) |-> frm_q.falls == SMP_CNT);

    // R4: the channel only moves on a rising I/O clock edge of an open frame
    a_r4_chan_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !(frm_q.open && evt.rise) |=> $stable(frm_q.chan));

    // R7: a conversion is only launched at the end of a full frame
    a_r7_start_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        frm_q.start |-> frm_q.falls == FRM_CNT);

    // R9: with chip select released, no sampling window survives
    a_r9_idle_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
        !evt.sel |=> !frm_q.samp);
endmodule

// File: rtl/sp_conv_stub.sv
module sp_conv_stub import adc_sp_pkg::*; #(
    parameter int CONV_CYCLES = 24,
    parameter int N_CH        = 11,
    parameter int CODE_STEP   = 372,
    parameter int CODE_OFS    = 3
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  addr_t   chan,
    output logic    eoc,
    output logic    load,
    output result_t result
);
    localparam int TW = $clog2(CONV_CYCLES + 1);
    localparam logic [TW-1:0] LAT = TW'(CONV_CYCLES - 1);
    localparam result_t MID = result_t'(1) << (RES_W - 1);

    typedef struct packed {
        logic          busy;
        logic [TW-1:0] cnt;
        addr_t         ch;
        logic          eoc;
        logic          load;
        result_t       res;
    } cv_t;

    cv_t cv_q, cv_d;

    function automatic result_t code_of(input addr_t a);
        int v;
        v = int'(a);
        if (v < N_CH)           return result_t'(v * CODE_STEP + CODE_OFS);
        else if (v == N_CH)     return MID;
        else if (v == N_CH + 1) return '0;
        else                    return '1;
    endfunction

    always_comb begin
        cv_d      = cv_q;
        cv_d.load = 1'b0;
        if (cv_q.load) cv_d.eoc = 1'b1;
        if (start) begin
            cv_d.busy = 1'b1;
            cv_d.cnt  = LAT;
            cv_d.ch   = chan;
            cv_d.eoc  = 1'b0;
        end else if (cv_q.busy) begin
            if (cv_q.cnt == '0) begin
                cv_d.busy = 1'b0;
                cv_d.load = 1'b1;
                cv_d.res  = code_of(cv_q.ch);
            end else begin
                cv_d.cnt = cv_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cv_q     <= '0;
            cv_q.eoc <= 1'b1;
        end else begin
            cv_q <= cv_d;
        end
    end

    assign eoc    = cv_q.eoc;
    assign load   = cv_q.load;
    assign result = cv_q.res;

    // R7: the flag is low the cycle after a launch
    a_r7_eoc_drops: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !cv_q.eoc);

    // R7: the flag only rises right after the result was handed over
    a_r7_eoc_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cv_q.eoc) |-> $past(cv_q.load));
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port import adc_sp_pkg::*; #(
    parameter int CONV_CYCLES = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              eoc,
    output logic              sample_en,
    output logic [ADDR_W-1:0] chan_sel,
    output logic [CFG_W-1:0]  cfg_sel
);
    pin_evt_t evt;
    logic     conv_start;
    logic     conv_load;
    result_t  conv_res;
    addr_t    chan_w;

    sp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .sclk  (sclk),
        .sdi   (sdi),
        .evt   (evt)
    );

    sp_frame_seq u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .load      (conv_load),
        .load_val  (conv_res),
        .chan      (chan_w),
        .cfg       (cfg_sel),
        .sample_en (sample_en),
        .start     (conv_start),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    sp_conv_stub #(.CONV_CYCLES(CONV_CYCLES)) u_conv (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (conv_start),
        .chan   (chan_w),
        .eoc    (eoc),
        .load   (conv_load),
        .result (conv_res)
    );

    assign chan_sel = chan_w;

    // R2: the output pad is never enabled while the synchronized select is idle
    a_r2_pad_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !evt.sel |=> !sdo_oe);
endmodule

// File: tb/adc_serial_port_test.sv
module adc_serial_port_test;
    localparam int CONV = 24;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo, sdo_oe, eoc, sample_en;
    logic [3:0] chan_sel, cfg_sel;

    int n_chk = 0;
    int n_bad = 0;
    logic [11:0] exp_q[$];
    logic [11:0] rd_word;
    logic [3:0]  last_chan = 4'd0;
    event rd_done;

    always #2 clk = ~clk;

    adc_serial_port #(.CONV_CYCLES(CONV)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .eoc(eoc), .sample_en(sample_en),
        .chan_sel(chan_sel), .cfg_sel(cfg_sel)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] model(input logic [3:0] a);
        if (a < 4'd11)       return 12'(int'(a) * 372 + 3);
        else if (a == 4'd11) return 12'd2048;
        else if (a == 4'd12) return 12'd0;
        else                 return 12'd4095;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // monitor: compare each readout against the oldest expected result
    initial begin : monitor
        logic [11:0] e;
        forever begin
            @(rd_done);
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 readout with no expected item", int'(rd_word), 0);
            end else begin
                e = exp_q.pop_front();
                check(rd_word == e, "R3/R8 readout", int'(rd_word), int'(e));
            end
        end
    end

    // driver: one frame; stop_at < 12 drops the frame early
    task automatic frame(input logic [3:0] addr, input logic [3:0] cfg,
                         input logic junk, input int stop_at, input bit wait_end,
                         input bit overlap);
        logic [7:0]  cmd;
        logic [11:0] got;
        int          w;
        cmd = {addr, cfg};
        got = '0;
        cs_n = 1'b0;
        tick(HALF);
        w = 0;
        while (!eoc && w < 400) begin tick(1); w++; end
        tick(2);
        check(sdo_oe == 1'b1, "R2 pad enabled after select", int'(sdo_oe), 1);
        if (overlap)
            check(sdo == exp_q[0][11], "R10 new MSB after load in open frame",
                  int'(sdo), int'(exp_q[0][11]));
        for (int b = 0; b < 12; b++) begin
            if (b == stop_at) break;
            sdi = (b < 8) ? cmd[7-b] : junk;
            got = {got[10:0], sdo};
            sclk = 1'b1;
            tick(HALF);
            if (b == 2) check(chan_sel == last_chan, "R4 chan held before 4th rise",
                              int'(chan_sel), int'(last_chan));
            if (b == 3) begin
                check(chan_sel == addr, "R4 chan after 4th rise", int'(chan_sel), int'(addr));
                last_chan = addr;
            end
            if (b == 7) check(cfg_sel == cfg, "R4 cfg after 8th rise", int'(cfg_sel), int'(cfg));
            sclk = 1'b0;
            tick(HALF);
            if (b == 2)  check(sample_en == 1'b0, "R6 no sample before 4th fall", int'(sample_en), 0);
            if (b == 3)  check(sample_en == 1'b1, "R6 sample at 4th fall", int'(sample_en), 1);
            if (b == 10) check(sample_en == 1'b1, "R6 sample held to last fall", int'(sample_en), 1);
            if (b == 11) begin
                check(sample_en == 1'b0, "R6 sample drops at last fall", int'(sample_en), 0);
                check(eoc == 1'b0, "R7 eoc low after last fall", int'(eoc), 0);
            end
        end
        if (stop_at >= 12) begin
            check(chan_sel == addr, "R5 chan kept after trailing bits", int'(chan_sel), int'(addr));
            check(cfg_sel == cfg, "R5 cfg kept after trailing bits", int'(cfg_sel), int'(cfg));
            rd_word = got;
            ->rd_done;
            exp_q.push_back(model(addr));
        end
        cs_n = 1'b1;
        tick(HALF);
        check(sdo_oe == 1'b0, "R2 pad released after deselect", int'(sdo_oe), 0);
        if (stop_at < 12) begin
            check(sample_en == 1'b0, "R9 dropped frame clears sample", int'(sample_en), 0);
            check(eoc == 1'b1, "R9 dropped frame starts no conversion", int'(eoc), 1);
        end else if (wait_end) begin
            w = 2 * HALF;
            while (!eoc && w < 400) begin tick(1); w++; end
            check(w == CONV + 5, "R7 eoc rise latency", w, CONV + 5);
        end
    endtask

    initial begin : watchdog
        #(4 * 150000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : driver
        exp_q.push_back(12'd0);           // R1: held result after reset
        tick(5);
        rst_n = 1'b1;
        tick(5);
        check(sdo_oe == 1'b0, "R1 pad off after reset", int'(sdo_oe), 0);
        check(eoc == 1'b1, "R1 eoc high after reset", int'(eoc), 1);
        check(sample_en == 1'b0, "R1 sample off after reset", int'(sample_en), 0);
        check(chan_sel == 4'd0, "R1 chan zero after reset", int'(chan_sel), 0);

        frame(4'd0,  4'hA, 1'b1, 12, 1'b1, 1'b0);
        frame(4'd5,  4'h3, 1'b0, 12, 1'b1, 1'b0);
        frame(4'd10, 4'hF, 1'b1, 12, 1'b1, 1'b0);
        frame(4'd11, 4'h0, 1'b1, 12, 1'b1, 1'b0);
        frame(4'd12, 4'h5, 1'b1, 12, 1'b1, 1'b0);
        frame(4'd13, 4'h9, 1'b0, 12, 1'b1, 1'b0);
        frame(4'd15, 4'h6, 1'b1, 12, 1'b1, 1'b0);
        // R9: dropped frame, then the held result must still read out
        frame(4'd7,  4'h1, 1'b0, 6,  1'b1, 1'b0);
        frame(4'd3,  4'hC, 1'b1, 12, 1'b0, 1'b0);
        // R10: next frame opens while the conversion is still running
        frame(4'd9,  4'h2, 1'b0, 12, 1'b1, 1'b1);
        frame(4'd1,  4'h7, 1'b1, 12, 1'b1, 1'b0);
        tick(20);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule